// File: doc/BRIEF.md
# MMU command word decoder

This block sits beside an instruction sequencer and interprets the coprocessor instructions that manage a paged memory management unit. For each strobed pair of an opcode word and a 16-bit extension word, it reports one cycle later what kind of MMU command the pair represents. The report is a one-hot class vector, plus the operand fields that the class carries: a register index, a transfer direction, a condition code, a function-code field and a mask field. Encodings that match no pattern raise an illegal flag instead of a class.

The block also owns the MMU control registers: translation control (32 bits), supervisor root pointer (64 bits), CPU root pointer (64 bits) and status (16 bits). A register-move or status-move command starts a word-serial transfer over a simple data port. In the store direction the block drives the register contents out one word per cycle. In the load direction it waits for one word per beat from the external data path and commits the register only when the last beat arrives. Bit 31 of translation control drives a translation-enable output.

A small state machine sequences the transfer. ST_IDLE accepts commands. It moves to ST_SEND on a legal register-to-memory move, or to ST_RECV on a legal memory-to-register move. ST_SEND advances one beat per cycle and returns to ST_IDLE after its last beat. ST_RECV advances on each accepted input word and returns to ST_IDLE when the last word is committed.

Top module: `mmu_cmd_decoder`

## Requirements
- R1: Decode results appear on the clock edge after a strobe that was sampled in ST_IDLE. `dec_vld` pulses for one cycle. At most one bit of `cmd_class` is set. The class bits are: 0 load, 1 flush, 2 flush-root, 3 validate, 4 test, 5 register move, 6 status move, 7 branch, 8 set-on-condition, 9 decrement-and-branch. A strobe sampled while `busy` is high is ignored.
- R2: The opcode word selects the group. (op & 0xFFF8) == 0xF048 means decrement-and-branch, and this test wins over the others. Otherwise (op & 0xFFC0) is compared: 0xF040 means set-on-condition, 0xF080 and 0xF0C0 mean branch, and 0xF000 means the extension word is decoded further. Any other opcode is illegal.
- R3: `cond_code` is op[3:0] for a branch and ext[3:0] for set-on-condition or decrement-and-branch. It is 0 for every other class.
- R4: In the general group, (ext & 0xFDE0) == 0x2000 is a load and is tested first. `fc_field` = ext[4:0].
- R5: ext == 0x2800 is validate with `reg_sel` = 0. (ext & 0xFFF8) == 0x2C00 is validate with `reg_sel` = ext[2:0]. Both forms are tested before flush.
- R6: (ext & 0xE200) == 0x2000 is a flush, with `fc_field` = ext[4:0] and `fc_mask` = ext[8:5]. ext == 0xA000 is flush-root.
- R7: (ext & 0xE000) == 0x8000 is a test command, with `fc_field` = ext[4:0].
- R8: When ext[15:13] is 0 or 2, the word is a register move. `to_mem` = ext[9], where 1 means register to memory. `reg_sel` = ext[12:10]: 0 selects translation control, 2 the supervisor root pointer and 3 the CPU root pointer.
- R9: When ext[15:13] is 3, the word is a status move with direction ext[9]. It transfers a single beat carrying the 16-bit status in `dat_out[15:0]` or `dat_in[15:0]`.
- R10: Translation control moves as two beats, high 16 bits first, each beat in bits 15:0. A root pointer moves as two 32-bit beats, limit word first and then table address. Store beats leave on consecutive cycles, the first in the cycle where `dec_vld` is high.
- R11: `xlate_en` equals bit 31 of translation control. It changes only on the edge that commits the last beat of a translation-control load.
- R12: An unknown register selector, an unmatched ext[15:13] value or an unknown opcode group sets `illegal` with `cmd_class` = 0. No transfer starts, and no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Strobe qualifying op_word and ext_word |
| op_word | input | 16 | Coprocessor opcode word |
| ext_word | input | 16 | Command extension word |
| dec_vld | output | 1 | One-cycle pulse: decode outputs updated |
| cmd_class | output | 10 | One-hot command class |
| illegal | output | 1 | Unrecognised encoding |
| reg_sel | output | 3 | Register or address-register index |
| to_mem | output | 1 | 1 = register to memory |
| cond_code | output | 4 | Condition code |
| fc_field | output | 5 | Function-code / level operand |
| fc_mask | output | 4 | Flush mask operand |
| busy | output | 1 | Transfer in progress |
| dat_in_vld | input | 1 | Input word valid (load direction) |
| dat_in | input | DATA_W | Input word |
| dat_out_vld | output | 1 | Output word valid (store direction) |
| dat_out | output | DATA_W | Output word |
| xlate_en | output | 1 | Translation enable |

## Verification
A wrong classification priority shows up on `cmd_class` in the single cycle after the strobe. Examples are flush winning over validate, or set-on-condition winning over decrement-and-branch. A wrong beat counter or commit condition shows later, on a store of the same register. The store then returns swapped halves, a stale half or a value that an illegal command should not have touched, on the first read-back after the faulty load. A state machine that fails to leave ST_SEND or ST_RECV, or that accepts strobes while busy, produces an unexpected `dec_vld` or missing data beats within two cycles.

// File: rtl/mmu_cmd_pkg.sv
package mmu_cmd_pkg;

    localparam int WORD_W = 16;
    localparam int CLS_W  = 10;

    localparam int CL_LOAD   = 0;
    localparam int CL_FLUSH  = 1;
    localparam int CL_FLROOT = 2;
    localparam int CL_VALID  = 3;
    localparam int CL_TEST   = 4;
    localparam int CL_RMOVE  = 5;
    localparam int CL_SMOVE  = 6;
    localparam int CL_BRANCH = 7;
    localparam int CL_SETC   = 8;
    localparam int CL_DECBR  = 9;

    typedef enum logic [1:0] {
        TGT_TC  = 2'd0,
        TGT_SRP = 2'd1,
        TGT_CRP = 2'd2,
        TGT_SR  = 2'd3
    } tgt_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1,
        ST_RECV = 2'd2
    } st_e;

    typedef struct packed {
        logic [CLS_W-1:0] cls;
        logic             illegal;
        logic [2:0]       sel;
        logic             to_mem;
        logic [3:0]       cond;
        logic [4:0]       fc;
        logic [3:0]       mask;
        logic             xfer;
        tgt_e             tgt;
    } dec_t;

endpackage

// File: rtl/mmu_ext_classifier.sv
module mmu_ext_classifier
    import mmu_cmd_pkg::*;
(
    input  logic [WORD_W-1:0] op,
    input  logic [WORD_W-1:0] ext,
    output dec_t              d
);

    always_comb begin
        d         = '0;
        d.tgt     = TGT_TC;
        if ((op & 16'hFFF8) == 16'hF048) begin
            d.cls[CL_DECBR] = 1'b1;
            d.cond          = ext[3:0];
        end else if ((op & 16'hFFC0) == 16'hF040) begin
            d.cls[CL_SETC] = 1'b1;
            d.cond         = ext[3:0];
        end else if (((op & 16'hFFC0) == 16'hF080) || ((op & 16'hFFC0) == 16'hF0C0)) begin
            d.cls[CL_BRANCH] = 1'b1;
            d.cond           = op[3:0];
        end else if ((op & 16'hFFC0) == 16'hF000) begin
            if ((ext & 16'hFDE0) == 16'h2000) begin
                d.cls[CL_LOAD] = 1'b1;
                d.fc           = ext[4:0];
            end else if (ext == 16'h2800) begin
                d.cls[CL_VALID] = 1'b1;
            end else if ((ext & 16'hFFF8) == 16'h2C00) begin
                d.cls[CL_VALID] = 1'b1;
                d.sel           = ext[2:0];
            end else if ((ext & 16'hE200) == 16'h2000) begin
                d.cls[CL_FLUSH] = 1'b1;
                d.fc            = ext[4:0];
                d.mask          = ext[8:5];
            end else if (ext == 16'hA000) begin
                d.cls[CL_FLROOT] = 1'b1;
            end else if ((ext & 16'hE000) == 16'h8000) begin
                d.cls[CL_TEST] = 1'b1;
                d.fc           = ext[4:0];
            end else begin
                unique case (ext[15:13])
                    3'd0, 3'd2: begin
                        d.sel    = ext[12:10];
                        d.to_mem = ext[9];
                        unique case (ext[12:10])
                            3'd0: begin d.cls[CL_RMOVE] = 1'b1; d.xfer = 1'b1; d.tgt = TGT_TC;  end
                            3'd2: begin d.cls[CL_RMOVE] = 1'b1; d.xfer = 1'b1; d.tgt = TGT_SRP; end
                            3'd3: begin d.cls[CL_RMOVE] = 1'b1; d.xfer = 1'b1; d.tgt = TGT_CRP; end
                            default: begin
                                d.illegal = 1'b1;
                                d.sel     = '0;
                                d.to_mem  = 1'b0;
                            end
                        endcase
                    end
                    3'd3: begin
                        d.cls[CL_SMOVE] = 1'b1;
                        d.to_mem        = ext[9];
                        d.xfer          = 1'b1;
                        d.tgt           = TGT_SR;
                    end
                    default: d.illegal = 1'b1;
                endcase
            end
        end else begin
            d.illegal = 1'b1;
        end
    end

endmodule

// File: rtl/mmu_reg_bank.sv
module mmu_reg_bank
    import mmu_cmd_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              last,
    input  logic              beat,
    input  tgt_e              tgt,
    input  logic [DATA_W-1:0] wr_word,
    output logic [DATA_W-1:0] rd_word,
    output logic              xlate_en
);

    localparam int HW = DATA_W / 2;

    logic [DATA_W-1:0] tc_q;
    logic [DATA_W-1:0] srp_lim_q, srp_ptr_q;
    logic [DATA_W-1:0] crp_lim_q, crp_ptr_q;
    logic [HW-1:0]     sr_q;
    logic [DATA_W-1:0] stage_q;
    logic              xl_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tc_q      <= '0;
            srp_lim_q <= '0;
            srp_ptr_q <= '0;
            crp_lim_q <= '0;
            crp_ptr_q <= '0;
            sr_q      <= '0;
            stage_q   <= '0;
            xl_q      <= 1'b0;
        end else if (wr_en) begin
            if (!last) begin
                stage_q <= wr_word;
            end else begin
                unique case (tgt)
                    TGT_TC: begin
                        tc_q <= {stage_q[HW-1:0], wr_word[HW-1:0]};
                        xl_q <= stage_q[HW-1];
                    end
                    TGT_SRP: begin
                        srp_lim_q <= stage_q;
                        srp_ptr_q <= wr_word;
                    end
                    TGT_CRP: begin
                        crp_lim_q <= stage_q;
                        crp_ptr_q <= wr_word;
                    end
                    TGT_SR: sr_q <= wr_word[HW-1:0];
                endcase
            end
        end
    end

    always_comb begin
        rd_word = '0;
        unique case (tgt)
            TGT_TC:  rd_word[HW-1:0] = beat ? tc_q[HW-1:0] : tc_q[DATA_W-1:HW];
            TGT_SRP: rd_word = beat ? srp_ptr_q : srp_lim_q;
            TGT_CRP: rd_word = beat ? crp_ptr_q : crp_lim_q;
            TGT_SR:  rd_word[HW-1:0] = sr_q;
        endcase
    end

    assign xlate_en = xl_q;

endmodule

// File: rtl/mmu_cmd_decoder.sv
module mmu_cmd_decoder
    import mmu_cmd_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [15:0]       op_word,
    input  logic [15:0]       ext_word,
    output logic              dec_vld,
    output logic [9:0]        cmd_class,
    output logic              illegal,
    output logic [2:0]        reg_sel,
    output logic              to_mem,
    output logic [3:0]        cond_code,
    output logic [4:0]        fc_field,
    output logic [3:0]        fc_mask,
    output logic              busy,
    input  logic              dat_in_vld,
    input  logic [DATA_W-1:0] dat_in,
    output logic              dat_out_vld,
    output logic [DATA_W-1:0] dat_out,
    output logic              xlate_en
);

    dec_t d;
    st_e  state_q, state_d;
    logic beat_q, beat_d;
    logic last_q;
    tgt_e tgt_q;
    logic accept;
    logic last_beat;
    logic wr_en;

    mmu_ext_classifier u_cls (
        .op  (op_word),
        .ext (ext_word),
        .d   (d)
    );

    assign accept    = cmd_valid && (state_q == ST_IDLE);
    assign last_beat = (beat_q == last_q);
    assign wr_en     = (state_q == ST_RECV) && dat_in_vld;

    always_comb begin
        state_d = state_q;
        beat_d  = beat_q;
        unique case (state_q)
            ST_IDLE: begin
                beat_d = 1'b0;
                if (accept && d.xfer)
                    state_d = d.to_mem ? ST_SEND : ST_RECV;
            end
            ST_SEND: begin
                if (last_beat) state_d = ST_IDLE;
                else           beat_d  = beat_q + 1'b1;
            end
            ST_RECV: begin
                if (dat_in_vld) begin
                    if (last_beat) state_d = ST_IDLE;
                    else           beat_d  = beat_q + 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            beat_q  <= 1'b0;
            last_q  <= 1'b0;
            tgt_q   <= TGT_TC;
        end else begin
            state_q <= state_d;
            beat_q  <= beat_d;
            if (accept) begin
                tgt_q  <= d.tgt;
                last_q <= (d.tgt != TGT_SR);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_vld   <= 1'b0;
            cmd_class <= '0;
            illegal   <= 1'b0;
            reg_sel   <= '0;
            to_mem    <= 1'b0;
            cond_code <= '0;
            fc_field  <= '0;
            fc_mask   <= '0;
        end else begin
            dec_vld <= accept;
            if (accept) begin
                cmd_class <= d.cls;
                illegal   <= d.illegal;
                reg_sel   <= d.sel;
                to_mem    <= d.to_mem;
                cond_code <= d.cond;
                fc_field  <= d.fc;
                fc_mask   <= d.mask;
            end
        end
    end

    mmu_reg_bank #(.DATA_W(DATA_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .last     (last_beat),
        .beat     (beat_q),
        .tgt      (tgt_q),
        .wr_word  (dat_in),
        .rd_word  (dat_out),
        .xlate_en (xlate_en)
    );

    assign busy        = (state_q != ST_IDLE);
    assign dat_out_vld = (state_q == ST_SEND);

endmodule

// File: rtl/mmu_cmd_decoder_chk.sv
module mmu_cmd_decoder_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic       dec_vld,
    input logic [9:0] cmd_class,
    input logic       illegal,
    input logic       to_mem,
    input logic       busy,
    input logic       dat_in_vld,
    input logic       dat_out_vld,
    input logic       xlate_en
);

    assert_class_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cmd_class));

    assert_strobe_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy) |=> dec_vld);

    assert_ignore_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !dec_vld);

    assert_illegal_noclass_R12: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (cmd_class == '0));

    assert_illegal_no_xfer_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_vld && illegal) |-> !busy);

    assert_xlate_on_commit_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(xlate_en) |-> $past(dat_in_vld && busy));

    assert_status_one_beat_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_vld && cmd_class[6] && to_mem) |-> dat_out_vld ##1 !dat_out_vld);

    assert_move_two_beats_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_vld && cmd_class[5] && to_mem) |-> dat_out_vld ##1 dat_out_vld);

    assert_out_when_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        dat_out_vld |-> busy);

endmodule

bind mmu_cmd_decoder mmu_cmd_decoder_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .dec_vld     (dec_vld),
    .cmd_class   (cmd_class),
    .illegal     (illegal),
    .to_mem      (to_mem),
    .busy        (busy),
    .dat_in_vld  (dat_in_vld),
    .dat_out_vld (dat_out_vld),
    .xlate_en    (xlate_en)
);

// File: tb/sim_mmu_cmd_decoder.sv
`timescale 1ns/1ps
module sim_mmu_cmd_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [15:0] op_word = '0;
    logic [15:0] ext_word = '0;
    logic        dec_vld;
    logic [9:0]  cmd_class;
    logic        illegal;
    logic [2:0]  reg_sel;
    logic        to_mem;
    logic [3:0]  cond_code;
    logic [4:0]  fc_field;
    logic [3:0]  fc_mask;
    logic        busy;
    logic        dat_in_vld = 1'b0;
    logic [31:0] dat_in = '0;
    logic        dat_out_vld;
    logic [31:0] dat_out;
    logic        xlate_en;

    always #2.5 clk = ~clk;

    mmu_cmd_decoder u0 (.*);

    typedef struct {
        logic [27:0] fields;
        string       tag;
    } exp_t;

    exp_t        dq[$];
    logic [31:0] oq[$];
    string       oq_tag[$];
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // fields: cls(10) ill(1) sel(3) dir(1) cond(4) fc(5) mask(4)
    function automatic logic [27:0] pack(logic [9:0] c, logic il, logic [2:0] s, logic dr,
                                         logic [3:0] cc, logic [4:0] f, logic [3:0] m);
        return {c, il, s, dr, cc, f, m};
    endfunction

    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (dec_vld) begin
                if (dq.size() == 0) begin
                    check(1'b0, "R1 unexpected decode", {22'd0, cmd_class}, 32'd0);
                end else begin
                    exp_t e;
                    logic [27:0] a;
                    e = dq.pop_front();
                    a = pack(cmd_class, illegal, reg_sel, to_mem, cond_code, fc_field, fc_mask);
                    check(a == e.fields, e.tag, {4'd0, a}, {4'd0, e.fields});
                end
            end
            if (dat_out_vld) begin
                if (oq.size() == 0) begin
                    check(1'b0, "R10 unexpected data beat", dat_out, 32'd0);
                end else begin
                    logic [31:0] x;
                    string t;
                    x = oq.pop_front();
                    t = oq_tag.pop_front();
                    check(dat_out == x, t, dat_out, x);
                end
            end
        end
    end

    task automatic issue(input logic [15:0] op, input logic [15:0] ext,
                         input logic [27:0] f, input string tag);
        exp_t e;
        e.fields = f;
        e.tag    = tag;
        dq.push_back(e);
        @(negedge clk);
        op_word   = op;
        ext_word  = ext;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wr_reg(input logic [15:0] ext, input logic [27:0] f,
                          input logic [31:0] w0, input logic [31:0] w1, input int nb, input string tag);
        issue(16'hF000, ext, f, tag);
        dat_in_vld = 1'b1;
        dat_in     = w0;
        @(negedge clk);
        if (nb == 2) begin
            dat_in = w1;
            @(negedge clk);
        end
        dat_in_vld = 1'b0;
        dat_in     = '0;
    endtask

    task automatic rd_reg(input logic [15:0] ext, input logic [27:0] f,
                          input logic [31:0] w0, input logic [31:0] w1, input int nb, input string tag);
        oq.push_back(w0);
        oq_tag.push_back({tag, " beat0"});
        if (nb == 2) begin
            oq.push_back(w1);
            oq_tag.push_back({tag, " beat1"});
        end
        issue(16'hF000, ext, f, tag);
        repeat (nb + 1) @(negedge clk);
    endtask

    localparam logic [9:0] C_LOAD = 10'd1 << 0;
    localparam logic [9:0] C_FL   = 10'd1 << 1;
    localparam logic [9:0] C_FR   = 10'd1 << 2;
    localparam logic [9:0] C_VAL  = 10'd1 << 3;
    localparam logic [9:0] C_TST  = 10'd1 << 4;
    localparam logic [9:0] C_RM   = 10'd1 << 5;
    localparam logic [9:0] C_SM   = 10'd1 << 6;
    localparam logic [9:0] C_BR   = 10'd1 << 7;
    localparam logic [9:0] C_SC   = 10'd1 << 8;
    localparam logic [9:0] C_DB   = 10'd1 << 9;

    initial begin
        repeat (4) @(negedge clk);
        check(dec_vld == 1'b0 && busy == 1'b0 && dat_out_vld == 1'b0, "R1 reset idle",
              {29'd0, dec_vld, busy, dat_out_vld}, 32'd0);
        check(xlate_en == 1'b0 && cmd_class == '0, "R11 reset state", {21'd0, xlate_en, cmd_class}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4 load first
        issue(16'hF000, 16'h2013, pack(C_LOAD, 0, 0, 0, 0, 5'h13, 0), "R4 load");
        issue(16'hF000, 16'h2213, pack(C_LOAD, 0, 0, 0, 0, 5'h13, 0), "R4 load bit9");
        // R6 flush / flush-root
        issue(16'hF000, 16'h21A5, pack(C_FL, 0, 0, 0, 0, 5'h05, 4'hD), "R6 flush fields");
        issue(16'hF000, 16'hA000, pack(C_FR, 0, 0, 0, 0, 0, 0), "R6 flush-root");
        // R5 validate before flush
        issue(16'hF000, 16'h2800, pack(C_VAL, 0, 0, 0, 0, 0, 0), "R5 validate form1");
        issue(16'hF000, 16'h2C05, pack(C_VAL, 0, 3'd5, 0, 0, 0, 0), "R5 validate form2");
        // R7 test
        issue(16'hF000, 16'h9F17, pack(C_TST, 0, 0, 0, 0, 5'h17, 0), "R7 test");
        // R2/R3 groups and conditions
        issue(16'hF085, 16'h0000, pack(C_BR, 0, 0, 0, 4'h5, 0, 0), "R3 branch16 cond");
        issue(16'hF0C7, 16'h0000, pack(C_BR, 0, 0, 0, 4'h7, 0, 0), "R2 branch32");
        issue(16'hF040, 16'h000B, pack(C_SC, 0, 0, 0, 4'hB, 0, 0), "R3 set-on-cond");
        issue(16'hF04A, 16'h0003, pack(C_DB, 0, 0, 0, 4'h3, 0, 0), "R2 decbr precedence");
        issue(16'hF100, 16'h4200, pack(0, 1, 0, 0, 0, 0, 0), "R12 bad group");

        // R8/R11 TC write then read
        wr_reg(16'h4000, pack(C_RM, 0, 0, 0, 0, 0, 0), 32'h8000, 32'h1234, 2, "R8 tc write");
        check(xlate_en == 1'b1, "R11 enable set", {31'd0, xlate_en}, 32'd1);
        rd_reg(16'h4200, pack(C_RM, 0, 0, 1, 0, 0, 0), 32'h8000, 32'h1234, 2, "R10 tc read");
        // R8 root pointers
        wr_reg(16'h0800, pack(C_RM, 0, 3'd2, 0, 0, 0, 0), 32'hAAAA0001, 32'h00C0FFE0, 2, "R8 srp write");
        wr_reg(16'h4C00, pack(C_RM, 0, 3'd3, 0, 0, 0, 0), 32'h7FFF0002, 32'h12345670, 2, "R8 crp write");
        rd_reg(16'h0A00, pack(C_RM, 0, 3'd2, 1, 0, 0, 0), 32'hAAAA0001, 32'h00C0FFE0, 2, "R10 srp read");
        rd_reg(16'h4E00, pack(C_RM, 0, 3'd3, 1, 0, 0, 0), 32'h7FFF0002, 32'h12345670, 2, "R10 crp read");
        // R9 status
        wr_reg(16'h6000, pack(C_SM, 0, 0, 0, 0, 0, 0), 32'h0000BEEF, 32'h0, 1, "R9 sr write");
        rd_reg(16'h6200, pack(C_SM, 0, 0, 1, 0, 0, 0), 32'h0000BEEF, 32'h0, 1, "R9 sr read");

        // R12 illegal selector with data offered, then TC unchanged
        wr_reg(16'h4400, pack(0, 1, 0, 0, 0, 0, 0), 32'hFFFF, 32'hFFFF, 2, "R12 bad selector");
        check(busy == 1'b0, "R12 no transfer", {31'd0, busy}, 32'd0);
        wr_reg(16'h3200, pack(0, 1, 0, 0, 0, 0, 0), 32'h0, 32'h0, 2, "R12 bad top bits 1");
        issue(16'hF000, 16'hC000, pack(0, 1, 0, 0, 0, 0, 0), "R12 bad top bits 6");
        rd_reg(16'h4200, pack(C_RM, 0, 0, 1, 0, 0, 0), 32'h8000, 32'h1234, 2, "R12 tc untouched");
        check(xlate_en == 1'b1, "R12 enable untouched", {31'd0, xlate_en}, 32'd1);

        // R1 strobe ignored while busy: TC write strobe during an SRP read
        oq.push_back(32'hAAAA0001); oq_tag.push_back("R1 busy read beat0");
        oq.push_back(32'h00C0FFE0); oq_tag.push_back("R1 busy read beat1");
        issue(16'hF000, 16'h0A00, pack(C_RM, 0, 3'd2, 1, 0, 0, 0), "R1 busy read");
        check(busy == 1'b1, "R1 busy during send", {31'd0, busy}, 32'd1);
        ext_word   = 16'h4000;
        cmd_valid  = 1'b1;
        @(negedge clk);
        cmd_valid  = 1'b0;
        dat_in_vld = 1'b1;
        dat_in     = 32'h0;
        @(negedge clk);
        @(negedge clk);
        dat_in_vld = 1'b0;
        @(negedge clk);
        rd_reg(16'h4200, pack(C_RM, 0, 0, 1, 0, 0, 0), 32'h8000, 32'h1234, 2, "R1 ignored strobe");

        // R11 clear enable
        wr_reg(16'h4000, pack(C_RM, 0, 0, 0, 0, 0, 0), 32'h0000, 32'h0001, 2, "R11 tc clear");
        check(xlate_en == 1'b0, "R11 enable cleared", {31'd0, xlate_en}, 32'd0);

        repeat (3) @(negedge clk);
        check(dq.size() == 0 && oq.size() == 0, "R1 all results seen",
              dq.size() + oq.size(), 32'd0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL R1 watchdog expired actual=hung expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule